// File: doc/BRIEF.md
# ROM Patch Trap Comparator

This block sits beside a processor's instruction-fetch path and compares every fetch address with a bank of programmable trap words. Software loads a trap word with the address of a faulty instruction in boot ROM and sets that word's enable bit. When a valid fetch hits an enabled word, the block raises a one-cycle bus-fault pulse. The exception handler then redirects execution to patched code that lives somewhere else.

The block also keeps a sticky fault record: a flag and the number of the trap word that fired. Software can drop the record in two ways. It can write zero into the flag bit of the record itself, or it can write one into a separate clear location. While the record is set, further traps still fault but do not replace the stored number. The handler therefore always sees the first trap since the last clear.

Top module: `patch_trap_unit`

## Requirements
- R1: After reset, `bus_fault` is 0, every trap word reads 0, the enable word reads 0 and the fault record reads 0.
- R2: Trap word n (n from 0 to NUM_ENTRIES-1, default 30) is written and read at byte offset 4*n and holds a full 32-bit address.
- R3: The enable word sits at offset 0x78, with bit n enabling trap word n. Bits at and above NUM_ENTRIES read 0 whatever was written to them.
- R4: `bus_fault` is 1 in the cycle after a cycle with `fetch_valid`=1 and a `fetch_addr` equal to an enabled trap word, and 0 in all other cycles. Each qualifying fetch gives exactly one pulse, so back-to-back qualifying fetches give back-to-back pulses. A matching address with `fetch_valid`=0, a disabled word, or an address that differs in any bit gives no pulse.
- R5: The fault record sits at offset 0x7C: bit 0 is the sticky flag and bits [5:1] hold the number of the trap word that fired. The record updates on the same clock edge that raises `bus_fault`.
- R6: When several enabled words match one fetch, the lowest-numbered word is recorded.
- R7: While the flag is set, a new trap still pulses `bus_fault`, but the recorded number is kept.
- R8: Writing a value with bit 0 = 0 to offset 0x7C clears the whole record to 0. Writing a value with bit 0 = 1 there leaves the record unchanged, and the number field is never written by software.
- R9: Writing bit 0 = 1 to offset 0xA8 clears the record, and writing bit 0 = 0 there has no effect. Offset 0xA8 and every unmapped offset read as 0.
- R10: If a clear and a qualifying fetch fall in the same cycle, the new trap is recorded: the flag stays 1 and the number becomes that of the new trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe for this cycle |
| reg_addr | input | 8 | Register byte offset (used for both reads and writes) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| fetch_valid | input | 1 | Instruction fetch present this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| bus_fault | output | 1 | Registered one-cycle fault pulse |

## Verification
A wrong trap word or enable bit shows up as a missing or extra `bus_fault` exactly one cycle after the fetch that probes it, and the record read at 0x7C after that edge then disagrees with the expected number. A priority encoder that picks the wrong match is visible as soon as two enabled words share an address. A record that is overwritten while set, or a clear decoded at the wrong polarity, is visible on the next read of 0x7C after the second trap or the clear write. The tests therefore pair each fetch with a fault sample taken one edge later and a read of the record.

// File: rtl/patch_trap_pkg.sv
package patch_trap_pkg;

    // Register port geometry
    localparam int REG_AW      = 8;
    localparam int REG_DW      = 32;
    localparam int MAX_ENTRIES = 30;
    localparam int IDX_W       = 5;

    // Fixed control offsets (software depends on these)
    localparam logic [REG_AW-1:0] OFS_ENABLE = 8'h78;
    localparam logic [REG_AW-1:0] OFS_STATUS = 8'h7C;
    localparam logic [REG_AW-1:0] OFS_CLEAR  = 8'hA8;

    // Bit position of the sticky flag in status and clear words
    localparam int FLAG_BIT = 0;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_ENTRY,
        RSEL_ENABLE,
        RSEL_STATUS,
        RSEL_CLEAR
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e               sel;
        logic [IDX_W-1:0]       entry;
    } reg_target_t;

    typedef struct packed {
        logic                   hit;
        logic [IDX_W-1:0]       idx;
    } match_t;

    typedef struct packed {
        logic                   flag;
        logic [IDX_W-1:0]       idx;
    } status_t;

    // Map a byte offset onto a register target; entries occupy word slots
    // 0..n-1 from offset zero.
    function automatic reg_target_t decode_reg(input logic [REG_AW-1:0] a,
                                               input int n);
        reg_target_t t;
        t.sel   = RSEL_NONE;
        t.entry = '0;
        if (a[1:0] == 2'b00) begin
            if (int'(a[REG_AW-1:2]) < n) begin
                t.sel   = RSEL_ENTRY;
                t.entry = a[2 +: IDX_W];
            end else if (a == OFS_ENABLE) begin
                t.sel = RSEL_ENABLE;
            end else if (a == OFS_STATUS) begin
                t.sel = RSEL_STATUS;
            end else if (a == OFS_CLEAR) begin
                t.sel = RSEL_CLEAR;
            end
        end
        return t;
    endfunction

    // Status word layout: flag in bit 0, entry number right above it
    function automatic logic [REG_DW-1:0] pack_status(input status_t s);
        logic [REG_DW-1:0] w;
        w = '0;
        w[FLAG_BIT]            = s.flag;
        w[FLAG_BIT+1 +: IDX_W] = s.idx;
        return w;
    endfunction

endpackage

// File: rtl/pt_entry_bank.sv
module pt_entry_bank
    import patch_trap_pkg::*;
#(
    parameter int NUM_ENTRIES = MAX_ENTRIES,
    parameter int ADDR_W      = 32
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  reg_target_t                        target,
    input  logic [REG_DW-1:0]                  wdata,
    output logic [NUM_ENTRIES-1:0][ADDR_W-1:0] entries,
    output logic [NUM_ENTRIES-1:0]             enables
);

    // One storage word per trap entry
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_word
        logic sel_this;
        assign sel_this = wr_en && (target.sel == RSEL_ENTRY) &&
                          (int'(target.entry) == g);
        always_ff @(posedge clk) begin
            if (rst) begin
                entries[g] <= '0;
            end else if (sel_this) begin
                entries[g] <= wdata[ADDR_W-1:0];
            end
        end
    end

    // Enable word keeps only the implemented low bits
    always_ff @(posedge clk) begin
        if (rst) begin
            enables <= '0;
        end else if (wr_en && target.sel == RSEL_ENABLE) begin
            enables <= wdata[NUM_ENTRIES-1:0];
        end
    end

endmodule

// File: rtl/pt_match_array.sv
module pt_match_array
    import patch_trap_pkg::*;
#(
    parameter int NUM_ENTRIES = MAX_ENTRIES,
    parameter int ADDR_W      = 32
) (
    input  logic                               fetch_valid,
    input  logic [ADDR_W-1:0]                  fetch_addr,
    input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] entries,
    input  logic [NUM_ENTRIES-1:0]             enables,
    output match_t                             result
);

    logic [NUM_ENTRIES-1:0] equal_vec;

    // Parallel comparators, one per enabled entry
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign equal_vec[g] = enables[g] && (entries[g] == fetch_addr);
    end

    // Priority select: lowest-numbered matching entry wins
    always_comb begin
        result.hit = fetch_valid && (|equal_vec);
        result.idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (equal_vec[i]) begin
                result.idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pt_fault_status.sv
module pt_fault_status
    import patch_trap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  match_t  match_in,
    input  logic    clr_req,
    output status_t status,
    output logic    fault
);

    logic keep_record;

    // The existing record survives only if it is set and not being cleared
    assign keep_record = status.flag && !clr_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            fault  <= 1'b0;
        end else begin
            fault <= match_in.hit;
            if (match_in.hit && !keep_record) begin
                status.flag <= 1'b1;
                status.idx  <= match_in.idx;
            end else if (clr_req) begin
                status <= '0;
            end
        end
    end

endmodule

// File: rtl/patch_trap_unit.sv
module patch_trap_unit
    import patch_trap_pkg::*;
#(
    parameter int NUM_ENTRIES = MAX_ENTRIES,
    parameter int ADDR_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              bus_fault
);

    reg_target_t                        target;
    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] entries;
    logic [NUM_ENTRIES-1:0]             enables;
    match_t                             match_w;
    status_t                            status;
    logic                               clr_req;
    logic                               trap_hit;

    assign target   = decode_reg(reg_addr, NUM_ENTRIES);
    assign trap_hit = match_w.hit;

    // Two clear paths: zero into the status flag, or one into the clear word
    assign clr_req = reg_wr_en &&
                     (((target.sel == RSEL_STATUS) && !reg_wdata[FLAG_BIT]) ||
                      ((target.sel == RSEL_CLEAR)  &&  reg_wdata[FLAG_BIT]));

    pt_entry_bank #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ADDR_W      (ADDR_W)
    ) i_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .target  (target),
        .wdata   (reg_wdata),
        .entries (entries),
        .enables (enables)
    );

    pt_match_array #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ADDR_W      (ADDR_W)
    ) i_match (
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .entries     (entries),
        .enables     (enables),
        .result      (match_w)
    );

    pt_fault_status i_status (
        .clk      (clk),
        .rst      (rst),
        .match_in (match_w),
        .clr_req  (clr_req),
        .status   (status),
        .fault    (bus_fault)
    );

    // Read mux; clear word and holes read as zero
    always_comb begin
        reg_rdata = '0;
        unique case (target.sel)
            RSEL_ENTRY:  reg_rdata[ADDR_W-1:0]      = entries[target.entry];
            RSEL_ENABLE: reg_rdata[NUM_ENTRIES-1:0] = enables;
            RSEL_STATUS: reg_rdata                  = pack_status(status);
            default:     reg_rdata                  = '0;
        endcase
    end

endmodule

// File: rtl/patch_trap_checker.sv
module patch_trap_checker
    import patch_trap_pkg::*;
#(
    parameter int NUM_ENTRIES = MAX_ENTRIES
) (
    input logic        clk,
    input logic        rst,
    input logic        fetch_valid,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_rdata,
    input logic        bus_fault,
    input logic        trap_hit,
    input logic        clr_req,
    input status_t     status
);

    assert_fault_needs_fetch_R4: assert property (@(posedge clk) disable iff (rst)
        bus_fault |-> $past(fetch_valid));

    assert_fault_has_record_R5: assert property (@(posedge clk) disable iff (rst)
        bus_fault |-> status.flag);

    assert_index_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        status.flag |-> (int'(status.idx) < NUM_ENTRIES));

    assert_index_held_R7: assert property (@(posedge clk) disable iff (rst)
        (status.flag && !clr_req) |=> $stable(status.idx) && status.flag);

    assert_clear_drops_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !trap_hit) |=> !status.flag);

    assert_enable_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_ENABLE) |-> (reg_rdata[31:NUM_ENTRIES] == '0));

    assert_idle_record_zero_R1: assert property (@(posedge clk) disable iff (rst)
        !status.flag |-> (status.idx == '0));

endmodule

bind patch_trap_unit patch_trap_checker #(.NUM_ENTRIES(NUM_ENTRIES)) i_checker (
    .clk         (clk),
    .rst         (rst),
    .fetch_valid (fetch_valid),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .bus_fault   (bus_fault),
    .trap_hit    (trap_hit),
    .clr_req     (clr_req),
    .status      (status)
);

// File: tb/test_patch_trap_unit.sv
module test_patch_trap_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        bus_fault;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;   // 125 MHz

    patch_trap_unit i_patch_trap_unit (
        .clk         (clk),
        .rst         (rst),
        .reg_wr_en   (reg_wr_en),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .bus_fault   (bus_fault)
    );

    typedef struct packed {
        logic [4:0]  idx;
        logic [31:0] val;
        logic [31:0] en;
        logic [31:0] fetch;
        logic        exp_fault;
        logic [31:0] exp_stat;
    } vec_t;

    // Entries accumulate across vectors; status is cleared before each fetch
    localparam vec_t VEC [10] = '{
        '{5'd0,  32'h1000_0000, 32'h0000_0001, 32'h1000_0000, 1'b1, 32'h01},
        '{5'd29, 32'h1000_1FFC, 32'h2000_0001, 32'h1000_1FFC, 1'b1, 32'h3B},
        '{5'd5,  32'h1000_0040, 32'h2000_0001, 32'h1000_0040, 1'b0, 32'h00},
        '{5'd5,  32'h1000_0040, 32'h2000_0021, 32'h1000_0040, 1'b1, 32'h0B},
        '{5'd3,  32'h1000_0040, 32'h2000_0029, 32'h1000_0040, 1'b1, 32'h07},
        '{5'd3,  32'h1000_0040, 32'hFFFF_FFFF, 32'h1000_0044, 1'b0, 32'h00},
        '{5'd10, 32'h0000_0000, 32'h0000_0400, 32'h0000_0000, 1'b1, 32'h15},
        '{5'd0,  32'h1000_0000, 32'h0000_0000, 32'h1000_0000, 1'b0, 32'h00},
        '{5'd2,  32'h8000_0001, 32'h0000_0004, 32'h8000_0000, 1'b0, 32'h00},
        '{5'd2,  32'h8000_0001, 32'h0000_0004, 32'h8000_0001, 1'b1, 32'h05}
    };

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // One fetch cycle; returns bus_fault sampled after the following edge
    task automatic do_fetch(input logic [31:0] a, output logic f);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        @(negedge clk);
        fetch_valid = 1'b0;
        f = bus_fault;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        f, f1, f2, f3;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 fault", {31'b0, bus_fault}, 32'h0);
        reg_read(8'h78, rd); check("R1 enable", rd, 32'h0);
        reg_read(8'h7C, rd); check("R1 status", rd, 32'h0);
        reg_read(8'h00, rd); check("R1 entry0", rd, 32'h0);
        reg_read(8'h74, rd); check("R1 entry29", rd, 32'h0);

        // Vector walk: R4 R5 R6 (match, enable gating, priority, record)
        foreach (VEC[k]) begin
            reg_write({VEC[k].idx, 2'b00}, VEC[k].val);
            reg_write(8'h78, VEC[k].en);
            reg_write(8'hA8, 32'h1);
            do_fetch(VEC[k].fetch, f);
            check($sformatf("R4 vector %0d fault", k), {31'b0, f}, {31'b0, VEC[k].exp_fault});
            reg_read(8'h7C, rd);
            check($sformatf("R5 R6 vector %0d status", k), rd, VEC[k].exp_stat);
        end

        // R2 entry storage
        reg_write(8'h44, 32'hDEAD_BEEF);
        reg_read(8'h44, rd); check("R2 entry17", rd, 32'hDEAD_BEEF);
        reg_read(8'h74, rd); check("R2 entry29", rd, 32'h1000_1FFC);

        // R3 enable width
        reg_write(8'h78, 32'hFFFF_FFFF);
        reg_read(8'h78, rd); check("R3 upper bits", rd, 32'h3FFF_FFFF);
        reg_write(8'h78, 32'h2000_0001);
        reg_read(8'h78, rd); check("R3 readback", rd, 32'h2000_0001);

        // R9 clear word (status holds 0x05 from last vector)
        reg_write(8'hA8, 32'h0);
        reg_read(8'h7C, rd); check("R9 zero write ignored", rd, 32'h05);
        reg_write(8'hA8, 32'h1);
        reg_read(8'h7C, rd); check("R9 one clears", rd, 32'h0);
        reg_read(8'hA8, rd); check("R9 clear reads zero", rd, 32'h0);
        reg_read(8'h80, rd); check("R9 hole reads zero", rd, 32'h0);

        // R7 record held while set
        do_fetch(32'h1000_0000, f);
        check("R7 first fault", {31'b0, f}, 32'h1);
        do_fetch(32'h1000_1FFC, f);
        check("R7 second fault", {31'b0, f}, 32'h1);
        reg_read(8'h7C, rd); check("R7 index kept", rd, 32'h01);

        // R8 status-write clear polarity
        reg_write(8'h7C, 32'h0000_003F);
        reg_read(8'h7C, rd); check("R8 one write ignored", rd, 32'h01);
        reg_write(8'h7C, 32'h0);
        reg_read(8'h7C, rd); check("R8 zero clears", rd, 32'h0);

        // R4 valid low with matching address
        @(negedge clk);
        fetch_valid = 1'b0;
        fetch_addr  = 32'h1000_0000;
        @(negedge clk);
        check("R4 no valid", {31'b0, bus_fault}, 32'h0);
        reg_read(8'h7C, rd); check("R4 no valid status", rd, 32'h0);

        // R4 back-to-back pulses, R7 first one recorded
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = 32'h1000_0000;
        @(negedge clk);
        fetch_addr  = 32'h1000_1FFC;
        f1 = bus_fault;
        @(negedge clk);
        fetch_valid = 1'b0;
        f2 = bus_fault;
        @(negedge clk);
        f3 = bus_fault;
        check("R4 pulse 1", {31'b0, f1}, 32'h1);
        check("R4 pulse 2", {31'b0, f2}, 32'h1);
        check("R4 pulse ends", {31'b0, f3}, 32'h0);
        reg_read(8'h7C, rd); check("R7 back-to-back record", rd, 32'h01);

        // R10 clear and trap in the same cycle
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_addr    = 8'hA8;
        reg_wdata   = 32'h1;
        fetch_valid = 1'b1;
        fetch_addr  = 32'h1000_1FFC;
        @(negedge clk);
        reg_wr_en   = 1'b0;
        fetch_valid = 1'b0;
        f = bus_fault;
        check("R10 fault", {31'b0, f}, 32'h1);
        reg_read(8'h7C, rd); check("R10 new record", rd, 32'h3B);

        summary();
        $finish;
    end

endmodule